// File: doc/BRIEF.md
# DDS tuning register write decoder

This block sits between a serial front end and a direct digital synthesis core. The front end delivers one 16-bit word per strobe. The block decodes the top two bits of each word and applies it as one of three writes: a mode/control update, a write to one of two 28-bit frequency tuning words, or a write to one of two 12-bit phase offsets. The four tuning registers and the frequency and phase select bits are driven straight to the synthesis core.

A frequency word is 28 bits wide, but each frequency write carries only 14 bits. A mode bit picks how those payloads are applied. In paired mode, two writes to the same address deliver the low half and then the high half. Both halves reach the register together, so the core never sees a half-updated tuning word. In split mode, each write replaces either the high or the low half on its own, as chosen by a half-select bit. This allows coarse or fine retuning in a single write.

Top module: `dds_tune_regs`

## Requirements
- R1: Bits [15:14] of a strobed word select the target: 00 is a control write, 01 targets frequency word 0, 10 targets frequency word 1, and 11 targets a phase register. On a frequency write, bits [13:0] are the 14-bit payload.
- R2: A control write latches four bits: paired mode from bit 13, half select from bit 12, frequency select from bit 11 (driven on `fsel`) and phase select from bit 10 (driven on `psel`).
- R3: In paired mode (bit 13 = 1), the first write to a frequency address supplies bits [13:0]. The next write to the same address supplies bits [27:14], and the full word is loaded on that write. For example, the words 0x2000, 0x4000, 0x7FFF leave frequency word 0 at 0xFFFC000.
- R4: In paired mode, the first write of a pair leaves both frequency outputs unchanged. No half-written value is ever visible.
- R5: A control write abandons a half-finished pair. The next frequency write is then treated as the first write of a new pair.
- R6: In paired mode, a write to the other frequency address abandons the pending pair and becomes the first write of a new pair for that address. The first address keeps its old value.
- R7: In split mode (bit 13 = 0) with half select 0, a frequency write replaces only bits [13:0]. For example, 0x0000 then 0xBFFF sets the low half of frequency word 1 to 0x3FFF.
- R8: In split mode with half select 1, a frequency write replaces only bits [27:14]. For example, 0x1000 then 0x40FF sets the high half of frequency word 0 to 0x00FF.
- R9: On a phase write, bit 13 picks phase register 0 (value 0) or phase register 1 (value 1), and bits [11:0] are the value. Bit 12 has no effect.
- R10: A phase write between the two halves of a pair does not disturb the pending pair.
- R11: When `wr_en` is low, the value on `wr_word` changes nothing.
- R12: A synchronous active-high reset clears all tuning words, the selects, the mode bits and any pending pair to zero.
- R13: Every register output takes its new value on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Strobe: one word per cycle when high |
| wr_word | input | 16 | Command word |
| freq0 | output | 28 | Frequency tuning word 0 |
| freq1 | output | 28 | Frequency tuning word 1 |
| phase0 | output | 12 | Phase offset 0 |
| phase1 | output | 12 | Phase offset 1 |
| fsel | output | 1 | Frequency word select for the core |
| psel | output | 1 | Phase offset select for the core |

## Verification
The hardest states to reach are the pending half of a paired load and the three ways that pair can be disrupted: a control write, a write to the other address, or an unrelated phase write in between. None of these states shows at the ports until a later write completes or fails to complete the pair. The stimulus builds each disruption as an explicit word sequence. It then infers the hidden pending state from the value the following write produces. For example, after a control write, two more writes are needed before the word appears. After a rebinding write, the new address commits on its second write and the old address stays unchanged.

// File: rtl/dds_tune_regs.sv
module dds_tune_regs #(
  parameter int HALF_W  = 14,
  parameter int PHASE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [15:0]         wr_word,
  output logic [2*HALF_W-1:0] freq0,
  output logic [2*HALF_W-1:0] freq1,
  output logic [PHASE_W-1:0]  phase0,
  output logic [PHASE_W-1:0]  phase1,
  output logic                fsel,
  output logic                psel
);
  localparam int FW = 2 * HALF_W;

  logic [1:0]        op;
  logic              tgt;
  logic [HALF_W-1:0] payload;
  logic [FW-1:0]     fq [2];
  logic [HALF_W-1:0] stage_q;
  logic              pend_q, pend_tgt_q;
  logic              paired_q, hi_q;

  assign op      = wr_word[15:14];
  assign tgt     = op[1];
  assign payload = wr_word[HALF_W-1:0];
  assign freq0   = fq[0];
  assign freq1   = fq[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fq[0]      <= '0;
      fq[1]      <= '0;
      phase0     <= '0;
      phase1     <= '0;
      stage_q    <= '0;
      pend_q     <= 1'b0;
      pend_tgt_q <= 1'b0;
      paired_q   <= 1'b0;
      hi_q       <= 1'b0;
      fsel       <= 1'b0;
      psel       <= 1'b0;
    end else if (wr_en) begin
      case (op)
        2'b00: begin
          paired_q <= wr_word[13];
          hi_q     <= wr_word[12];
          fsel     <= wr_word[11];
          psel     <= wr_word[10];
          pend_q   <= 1'b0;
        end
        2'b11: begin
          if (wr_word[13]) phase1 <= wr_word[PHASE_W-1:0];
          else             phase0 <= wr_word[PHASE_W-1:0];
        end
        default: begin
          if (paired_q) begin
            if (pend_q && pend_tgt_q == tgt) begin
              fq[tgt] <= {payload, stage_q};
              pend_q  <= 1'b0;
            end else begin
              stage_q    <= payload;
              pend_q     <= 1'b1;
              pend_tgt_q <= tgt;
            end
          end else if (hi_q) begin
            fq[tgt][FW-1:HALF_W] <= payload;
          end else begin
            fq[tgt][HALF_W-1:0] <= payload;
          end
        end
      endcase
    end
  end

  p_first_half_hidden_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op != 2'b00 && op != 2'b11 && paired_q && !(pend_q && pend_tgt_q == tgt))
      |=> ($stable(freq0) && $stable(freq1)));

  p_ctrl_keeps_freq_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 2'b00) |=> ($stable(freq0) && $stable(freq1)));

  p_phase_only_on_op3_r9: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && op == 2'b11)) |=> ($stable(phase0) && $stable(phase1)));

  p_selects_only_on_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && op == 2'b00)) |=> ($stable(fsel) && $stable(psel)));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ($stable(freq0) && $stable(freq1)));

  p_high_half_keeps_low_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 2'b01 && !paired_q && hi_q)
      |=> (freq0[HALF_W-1:0] == $past(freq0[HALF_W-1:0])));

  p_low_half_keeps_high_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 2'b10 && !paired_q && !hi_q)
      |=> (freq1[FW-1:HALF_W] == $past(freq1[FW-1:HALF_W])));
endmodule

// File: tb/test_dds_tune_regs.sv
module test_dds_tune_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_word;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  logic        fsel, psel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dds_tune_regs i_dds_tune_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
    .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
    .fsel(fsel), .psel(psel)
  );

  // selector: 0 freq0, 1 freq1, 2 phase0, 3 phase1, 4 {fsel,psel}
  localparam int N = 22;
  localparam logic [15:0] VW [N] = '{
    16'h2000, 16'h4000, 16'h7FFF, 16'h4001, 16'h2000, 16'h4002, 16'h4003,
    16'h4005, 16'h8006, 16'h8007, 16'h4009, 16'hC111, 16'h400A, 16'hD123,
    16'hE456, 16'h0000, 16'hBFFF, 16'h1000, 16'h40FF, 16'h0C00, 16'h0800,
    16'h9234};
  localparam int VS [N] = '{4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 2, 0, 2, 3, 1, 1, 0, 0, 4, 4, 1};
  localparam logic [27:0] VE [N] = '{
    28'h0, 28'h0, 28'hFFFC000, 28'hFFFC000, 28'hFFFC000, 28'hFFFC000, 28'h000C002,
    28'h000C002, 28'h0, 28'h001C006, 28'h000C002, 28'h111, 28'h0028009, 28'h123,
    28'h456, 28'h001C006, 28'h001FFFF, 28'h0028009, 28'h03FC009, 28'h3, 28'h2,
    28'h001D234};
  // requirement per entry: R2 R4 R3 R4 R5 R5 R5 R6 R6 R6 R6 R9 R10 R9 R9 R1 R7 R8 R8 R2 R2 R1
  localparam int VR [N] = '{2, 4, 3, 4, 5, 5, 5, 6, 6, 6, 6, 9, 10, 9, 9, 1, 7, 8, 8, 2, 2, 1};

  function automatic logic [27:0] pick(int s);
    case (s)
      0: return freq0;
      1: return freq1;
      2: return {16'h0, phase0};
      3: return {16'h0, phase1};
      default: return {26'h0, fsel, psel};
    endcase
  endfunction

  task automatic check(string req, logic [27:0] act, logic [27:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%07h expected=0x%07h", req, act, exp);
    end
  endtask

  task automatic put(logic [15:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_word = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_word = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12", freq0, 28'h0);
    check("R12", freq1, 28'h0);
    check("R12", {16'h0, phase0, phase1} , 28'h0);
    check("R12", {26'h0, fsel, psel}, 28'h0);

    for (int i = 0; i < N; i++) begin
      put(VW[i]);
      check($sformatf("R%0d", VR[i]), pick(VS[i]), VE[i]);
    end

    // R11: word present without strobe has no effect
    @(negedge clk);
    wr_word = 16'h7FFF;
    repeat (4) @(negedge clk);
    check("R11", freq0, 28'h03FC009);
    wr_word = 16'h0C00;
    repeat (2) @(negedge clk);
    check("R11", {26'h0, fsel, psel}, 28'h2);
    wr_word = 16'hC777;
    repeat (2) @(negedge clk);
    check("R11", {16'h0, phase0}, 28'h123);

    // R13: value appears right after the sampling edge, not before
    @(negedge clk);
    wr_en = 1'b1; wr_word = 16'hE0AA;
    @(posedge clk);
    #1;
    check("R13", {16'h0, phase1}, 28'h0AA);
    @(negedge clk);
    wr_en = 1'b0;

    // R12: reset mid-pair clears mode and pending state
    put(16'h2000);
    put(16'h4111);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R12", freq0, 28'h0);
    check("R12", {16'h0, phase1}, 28'h0);
    put(16'h4ABC);
    check("R12", freq0, 28'h0000ABC);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule